// File: doc/BRIEF.md
# Two-Bit Branch Predictor with Target Cache

This unit sits beside the fetch stage of an in-order pipeline. Each cycle it takes the fetch address and answers with three things: whether the target cache holds an entry for that address, whether the history counter for that address expects the branch to be taken, and the address fetch should use next. A redirect to a cached target happens only when both the cache hits and the counter leans taken. In every other case the unit hands back the sequential address, fetch_pc + 4.

When a branch resolves later in the pipeline, the resolving stage sends an update. The update carries the branch address, the real direction and the real target. The counter selected by that address moves one step toward the real direction. A taken branch also writes its target into the target cache. Both tables are indexed by low address bits after the two byte-offset bits are dropped. Both tables are cleared by reset.

Each history entry is a small state machine with four states. In `CNT_SNT` (strongly not-taken, code 00), a taken update moves it to `CNT_WNT` (weakly not-taken, 01). From `CNT_WNT`, a taken update moves it to `CNT_WT` (weakly taken, 10), and from `CNT_WT` a taken update moves it to `CNT_ST` (strongly taken, 11). `CNT_ST` stays where it is on a taken update. Not-taken updates walk the same chain the other way: `CNT_ST` → `CNT_WT` → `CNT_WNT` → `CNT_SNT`, and `CNT_SNT` stays put. Every entry starts in `CNT_WNT`.

Top module: `branch_predictor`

## Requirements
- R1: After reset every counter is in state 01 and every target cache entry is invalid. A lookup therefore gives pred_hit=0, pred_taken=0 and pred_target=fetch_pc+4.
- R2: The history table is indexed by fetch_pc[7:2], which gives 64 counters. The target cache is indexed by pc[5:2], which gives 16 entries, and its tag is pc[31:6]. Address bits 1:0 take no part in either index.
- R3: An update with upd_taken=1 moves the selected counter up by one step. A counter already at 11 stays at 11.
- R4: An update with upd_taken=0 moves the selected counter down by one step. A counter already at 00 stays at 00.
- R5: pred_taken is 1 exactly when the selected counter is 10 or 11. Starting from a strong state, the prediction changes only after two opposite outcomes in a row.
- R6: A taken update writes the selected target cache entry: the valid bit is set, the tag becomes upd_pc[31:6] and the target becomes upd_target. A not-taken update leaves the target cache unchanged.
- R7: pred_hit is 1 only when the indexed entry is valid and its tag equals fetch_pc[31:6]. A different address that maps to the same index misses.
- R8: pred_target equals the cached target only when pred_hit and pred_taken are both 1. Otherwise it equals fetch_pc+4.
- R9: When an update and a lookup select the same entry in the same cycle, the lookup returns the value the entry held before that update.
- R10: In a cycle with upd_valid=0, no counter and no target cache entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_pc | input | 32 | Address being fetched this cycle |
| pred_hit | output | 1 | The target cache holds a valid entry for fetch_pc |
| pred_taken | output | 1 | The counter for fetch_pc predicts taken |
| pred_target | output | 32 | Address to fetch next |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Real direction of the resolved branch |
| upd_target | input | 32 | Real target of the resolved branch |

## Verification
Assertions watch every cycle. They check each counter step up and down, saturation at both ends, that the history table holds steady in idle cycles, and that a taken update fills the target cache while a not-taken update leaves it alone. The bench's scenarios are needed for the behaviour seen at the ports. This covers the two-misprediction hysteresis, tag misses on aliased addresses, history aliasing between addresses 256 bytes apart, the rule for choosing the redirect address, and the pre-update value returned when a lookup and an update collide in the same cycle.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef enum logic [1:0] {
        CNT_SNT = 2'b00,
        CNT_WNT = 2'b01,
        CNT_WT  = 2'b10,
        CNT_ST  = 2'b11
    } cnt_state_e;

    // Transition function of one history entry
    function automatic cnt_state_e cnt_next(input cnt_state_e cur, input logic taken);
        cnt_state_e nxt;
        unique case (cur)
            CNT_SNT: nxt = taken ? CNT_WNT : CNT_SNT;
            CNT_WNT: nxt = taken ? CNT_WT  : CNT_SNT;
            CNT_WT:  nxt = taken ? CNT_ST  : CNT_WNT;
            CNT_ST:  nxt = taken ? CNT_ST  : CNT_WT;
            default: nxt = CNT_WNT;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/bp_history.sv
module bp_history
    import bp_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] look_idx,
    output logic             look_taken,
    input  logic             upd_valid,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_taken
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0][1:0] cnt_q;
    cnt_state_e            upd_cur;
    cnt_state_e            upd_nxt;
    cnt_state_e            look_state;

    assign upd_cur = cnt_state_e'(cnt_q[upd_idx]);
    assign upd_nxt = cnt_next(upd_cur, upd_taken);

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= {DEPTH{2'(CNT_WNT)}};
        end else if (upd_valid) begin
            cnt_q[upd_idx] <= 2'(upd_nxt);
        end
    end

    // Output process
    always_comb begin
        look_state = cnt_state_e'(cnt_q[look_idx]);
        unique case (look_state)
            CNT_SNT, CNT_WNT: look_taken = 1'b0;
            CNT_WT,  CNT_ST:  look_taken = 1'b1;
            default:          look_taken = 1'b0;
        endcase
    end

    p_count_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && cnt_q[upd_idx] != 2'b11)
        |=> cnt_q[$past(upd_idx)] == $past(cnt_q[upd_idx]) + 2'd1);

    p_sat_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && cnt_q[upd_idx] == 2'b11)
        |=> cnt_q[$past(upd_idx)] == 2'b11);

    p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && cnt_q[upd_idx] != 2'b00)
        |=> cnt_q[$past(upd_idx)] == $past(cnt_q[upd_idx]) - 2'd1);

    p_sat_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && cnt_q[upd_idx] == 2'b00)
        |=> cnt_q[$past(upd_idx)] == 2'b00);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(cnt_q));

endmodule

// File: rtl/bp_target.sv
module bp_target #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] look_pc,
    output logic            look_hit,
    output logic [PC_W-1:0] look_target,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int TAG_W = PC_W - IDX_W - 2;

    logic [DEPTH-1:0]            valid_q;
    logic [DEPTH-1:0][TAG_W-1:0] tag_q;
    logic [DEPTH-1:0][PC_W-1:0]  tgt_q;

    logic [IDX_W-1:0] look_idx;
    logic [TAG_W-1:0] look_tag;
    logic [IDX_W-1:0] upd_idx;
    logic [TAG_W-1:0] upd_tag;
    logic             fill;
    logic [1:0]       unused_low;

    assign look_idx   = look_pc[IDX_W+1:2];
    assign look_tag   = look_pc[PC_W-1:IDX_W+2];
    assign upd_idx    = upd_pc[IDX_W+1:2];
    assign upd_tag    = upd_pc[PC_W-1:IDX_W+2];
    assign fill       = upd_valid && upd_taken;
    assign unused_low = look_pc[1:0] ^ upd_pc[1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            tag_q   <= '0;
            tgt_q   <= '0;
        end else if (fill) begin
            valid_q[upd_idx] <= 1'b1;
            tag_q[upd_idx]   <= upd_tag;
            tgt_q[upd_idx]   <= upd_target;
        end
    end

    always_comb begin
        look_hit    = valid_q[look_idx] && (tag_q[look_idx] == look_tag);
        look_target = tgt_q[look_idx];
    end

    p_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken)
        |=> valid_q[$past(upd_idx)] && tgt_q[$past(upd_idx)] == $past(upd_target)
            && tag_q[$past(upd_idx)] == $past(upd_tag));

    p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_valid && upd_taken) |=> $stable(valid_q) && $stable(tgt_q) && $stable(tag_q));

endmodule

// File: rtl/branch_predictor.sv
module branch_predictor #(
    parameter int PC_W      = 32,
    parameter int HIST_IDX  = 6,
    parameter int TGT_IDX   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_hit,
    output logic            pred_taken,
    output logic [PC_W-1:0] pred_target,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target
);
    localparam logic [PC_W-1:0] STEP = PC_W'(4);

    logic [HIST_IDX-1:0] hist_look_idx;
    logic [HIST_IDX-1:0] hist_upd_idx;
    logic                hist_taken;
    logic                tgt_hit;
    logic [PC_W-1:0]     tgt_addr;
    logic [PC_W-1:0]     seq_pc;

    assign hist_look_idx = fetch_pc[HIST_IDX+1:2];
    assign hist_upd_idx  = upd_pc[HIST_IDX+1:2];
    assign seq_pc        = fetch_pc + STEP;

    bp_history #(.IDX_W(HIST_IDX)) u_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .look_idx   (hist_look_idx),
        .look_taken (hist_taken),
        .upd_valid  (upd_valid),
        .upd_idx    (hist_upd_idx),
        .upd_taken  (upd_taken)
    );

    bp_target #(.PC_W(PC_W), .IDX_W(TGT_IDX)) u_tgt (
        .clk         (clk),
        .rst_n       (rst_n),
        .look_pc     (fetch_pc),
        .look_hit    (tgt_hit),
        .look_target (tgt_addr),
        .upd_valid   (upd_valid),
        .upd_pc      (upd_pc),
        .upd_taken   (upd_taken),
        .upd_target  (upd_target)
    );

    always_comb begin
        pred_hit    = tgt_hit;
        pred_taken  = hist_taken;
        pred_target = (tgt_hit && hist_taken) ? tgt_addr : seq_pc;
    end

    // R8: without a taken hit the sequential address is always chosen
    p_fallthrough_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(pred_hit && pred_taken) |-> pred_target == fetch_pc + STEP);

endmodule

// File: tb/branch_predictor_bench.sv
`timescale 1ns/1ps
module branch_predictor_bench;

    typedef struct {
        logic        hit;
        logic        taken;
        logic [31:0] tgt;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        pred_hit;
    logic        pred_taken;
    logic [31:0] pred_target;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;

    int checks = 0;
    int errors = 0;
    exp_t q[$];
    exp_t e;

    int          m_cnt [64];
    bit          m_val [16];
    logic [25:0] m_tag [16];
    logic [31:0] m_tgt [16];

    always #2.5 clk = ~clk;

    branch_predictor u_branch_predictor (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
        .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_target(pred_target),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_target(upd_target)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and queues the expected lookup
    task automatic step(input logic [31:0] pc, input logic uv, input logic [31:0] upc,
                        input logic ut, input logic [31:0] utg, input string req);
        exp_t x;
        int hi;
        int bi;
        @(posedge clk);
        #1;
        fetch_pc = pc; upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_target = utg;
        hi = int'(pc[7:2]);
        bi = int'(pc[5:2]);
        x.hit   = m_val[bi] && (m_tag[bi] == pc[31:6]);
        x.taken = (m_cnt[hi] >= 2);
        x.tgt   = (x.hit && x.taken) ? m_tgt[bi] : pc + 32'd4;
        x.req   = req;
        q.push_back(x);
        if (uv) begin
            hi = int'(upc[7:2]);
            bi = int'(upc[5:2]);
            if (ut) begin
                if (m_cnt[hi] < 3) m_cnt[hi]++;
                m_val[bi] = 1'b1;
                m_tag[bi] = upc[31:6];
                m_tgt[bi] = utg;
            end else if (m_cnt[hi] > 0) begin
                m_cnt[hi]--;
            end
        end
    endtask

    task automatic look(input logic [31:0] pc, input string req);
        step(pc, 1'b0, 32'h0, 1'b0, 32'h0, req);
    endtask

    task automatic upd(input logic [31:0] pc, input logic t, input logic [31:0] tg,
                       input string req);
        step(pc, 1'b1, pc, t, tg, req);
    endtask

    // Monitor: compares the design against the queued expectation mid-cycle
    always @(negedge clk) begin
        if (rst_n && q.size() > 0) begin
            e = q.pop_front();
            check(e.req, "hit",    32'(pred_hit),   32'(e.hit));
            check(e.req, "taken",  32'(pred_taken), 32'(e.taken));
            check(e.req, "target", pred_target,     e.tgt);
        end
    end

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        for (int i = 0; i < 64; i++) m_cnt[i] = 1;
        for (int i = 0; i < 16; i++) begin
            m_val[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state seen through lookups
        look(32'h0000_0100, "R1");
        look(32'h0000_0FFC, "R1");
        look(32'h8000_0040, "R1");

        // R9: update and lookup on the same entry in one cycle
        step(32'h0000_0100, 1'b1, 32'h0000_0100, 1'b1, 32'h0000_2000, "R9");
        // R6/R8: entry filled, counter 10 -> redirect
        look(32'h0000_0100, "R6");
        upd(32'h0000_0100, 1'b1, 32'h0000_2000, "R3");
        upd(32'h0000_0100, 1'b1, 32'h0000_2000, "R3");
        look(32'h0000_0100, "R3");
        // R5: first wrong outcome from strong taken keeps taken
        upd(32'h0000_0100, 1'b0, 32'h0, "R5");
        look(32'h0000_0100, "R5");
        upd(32'h0000_0100, 1'b0, 32'h0, "R5");
        // R8: hit but not-taken gives sequential address
        look(32'h0000_0100, "R8");
        upd(32'h0000_0100, 1'b0, 32'h0, "R4");
        upd(32'h0000_0100, 1'b0, 32'h0, "R4");
        look(32'h0000_0100, "R4");
        upd(32'h0000_0100, 1'b1, 32'h0000_3000, "R5");
        look(32'h0000_0100, "R5");
        // R7: same cache index, different tag
        look(32'h0000_0140, "R7");
        look(32'h0001_0100, "R7");
        // R2: history alias 256 bytes apart, byte offset ignored
        upd(32'h0000_0100, 1'b1, 32'h0000_3000, "R2");
        look(32'h0000_0200, "R2");
        look(32'h0000_0103, "R2");
        // R10: idle cycles leave everything unchanged
        step(32'h0000_0100, 1'b0, 32'h0000_0100, 1'b1, 32'h0000_9999, "R10");
        look(32'h0000_0100, "R10");

        r = 32'h1234_5679;
        for (int i = 0; i < 400; i++) begin
            logic [31:0] pa;
            logic [31:0] pb;
            r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
            pa = {23'h0, r[8], r[7:2], 2'b00};
            pb = {23'h0, r[18], r[17:12], 2'b00};
            step(pa, r[20], pb, r[21], {16'h0, r[31:18], 2'b00}, "R3");
        end

        @(posedge clk);
        #1 upd_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule